// File: doc/BRIEF.md
# Two-Tier Interrupt Aggregation Controller

This block folds a set of board events into a single active-low, level-sensitive host interrupt. The events pass through two tiers. In the lower tier, each single-cycle event pulse sets its own sticky flag. Each flag has a separate enable bit. The enabled flags are ORed into a local summary. In the upper tier, a primary control register decides whether that local summary may reach the host. A DMA-completion flag is a second primary source. A global host enable gates the final line.

Software uses a small register port with a combinational read path and writes that take effect on the clock edge. Lower-tier flags are cleared by writing a zero to their bit. Writing a one leaves them alone. The DMA-completion flag is cleared by writing a one to bit 0 of its own register. A separate read-only view shows the raw live conditions, which are not latched. Bit 31 of the primary control register drives a user status indicator output, which is on after reset.

Top module: `irq_two_tier_hub`

## Requirements
- R1: A pulse on `local_evt_i[i]` sets latched flag i. The flag is readable at bit i of address 1 (local status) after the next rising edge, and it stays set while no clearing write arrives.
- R2: A write to address 1 clears every flag whose data bit is 0 and leaves every flag whose data bit is 1 unchanged.
- R3: When an event pulse and a clearing write for the same flag fall in the same cycle, the flag stays set. This applies to the local flags and to the DMA-completion flag.
- R4: The local summary is active when some flag is set and its enable bit at address 2 (local enable, bits [N_LOCAL-1:0]) is 1. The summary drives the interrupt only when bit 1 (local enable) of address 0 (primary control) is 1.
- R5: When bit 0 (host enable) of address 0 is 0, `irq_n_o` stays 1 whatever the sources are.
- R6: A pulse on `dma_done_i` sets bit 0 of address 4 (DMA status). Writing 1 to that bit clears it, and writing 0 has no effect.
- R7: A set DMA-completion flag drives the interrupt only when bit 2 (DMA enable) of address 0 is 1.
- R8: Address 3 returns `live_i` in bits [N_LIVE-1:0] in the same cycle, with no latching. Writes to address 3 change nothing.
- R9: After reset, every flag and enable is 0, address 0 reads 0x80000000, `irq_n_o` is 1 and `led_o` is 1.
- R10: Bit 31 of address 0 is read/write and drives `led_o`.
- R11: Bit 8 of address 0 is a read-only copy of the enabled local summary, taken before the local enable of R4. Unused bits and unused addresses 5 to 7 read 0.
- R12: With the default OUT_REG=0, `irq_n_o` falls right after the clock edge that latches an enabled event. It does not fall before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| local_evt_i | input | N_LOCAL | Single-cycle event pulses for the lower tier (bad data, receive FIFO almost full, own data returned, reset-node request) |
| dma_done_i | input | 1 | Single-cycle DMA completion pulse |
| live_i | input | N_LIVE | Raw, unlatched live conditions |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| irq_n_o | output | 1 | Active-low host interrupt |
| led_o | output | 1 | User status indicator, 1 = on |

## Verification
A flag update, an enable change and an interrupt change all land on the rising edge that samples the write or the pulse. Read data and `irq_n_o` follow that edge through logic only, with no further register. The live view has no register at all and follows `live_i` without waiting for an edge. The bench therefore drives each stimulus on a falling edge and lets one rising edge pass. It then moves the address to the register to be read and samples one nanosecond later. For the live view and for the edge-timing case of R12, it also samples before the edge to show that nothing has changed early.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
   localparam int REG_W = 32;

   // register select codes (software map)
   localparam logic [2:0] SEL_CTRL  = 3'd0;
   localparam logic [2:0] SEL_LSTAT = 3'd1;
   localparam logic [2:0] SEL_LEN   = 3'd2;
   localparam logic [2:0] SEL_LIVE  = 3'd3;
   localparam logic [2:0] SEL_DMA   = 3'd4;

   // primary control field positions
   localparam int B_HOST_IE  = 0;
   localparam int B_LOCAL_IE = 1;
   localparam int B_DMA_IE   = 2;
   localparam int B_PEND     = 8;
   localparam int B_LED      = 31;

   typedef struct packed {
      logic led;
      logic dma_ie;
      logic local_ie;
      logic host_ie;
   } prim_ctrl_t;
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_i,
   input  logic [WIDTH-1:0] clr_i,
   output logic [WIDTH-1:0] q_o
);
   initial begin
      assert (WIDTH >= 1 && WIDTH <= 32) else $error("irq_sticky_bank: WIDTH out of range");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        q_o[i] <= 1'b0;
         else if (set_i[i]) q_o[i] <= 1'b1;   // event has priority over clear
         else if (clr_i[i]) q_o[i] <= 1'b0;
      end

      // R1 / R3: an event always leaves the flag set
      a_r3_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> q_o[i]);
      // R1: a set flag holds without a clear request
      a_r1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (q_o[i] && !clr_i[i]) |=> q_o[i]);
      // R2: a clear without an event drops the flag
      a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[i] && !set_i[i]) |=> !q_o[i]);
   end
endmodule

// File: rtl/irq_local_tier.sv
module irq_local_tier #(
   parameter int N_LOCAL = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LOCAL-1:0] evt_i,
   input  logic               wr_stat_i,
   input  logic               wr_en_i,
   input  logic [N_LOCAL-1:0] wdata_i,
   output logic [N_LOCAL-1:0] flags_o,
   output logic [N_LOCAL-1:0] en_o,
   output logic               sum_o
);
   logic [N_LOCAL-1:0] clr_req;

   // writing zero to a bit position requests its clear
   assign clr_req = wr_stat_i ? ~wdata_i : '0;

   irq_sticky_bank #(.WIDTH(N_LOCAL)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (evt_i),
      .clr_i (clr_req),
      .q_o   (flags_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       en_o <= '0;
      else if (wr_en_i) en_o <= wdata_i;
   end

   assign sum_o = |(flags_o & en_o);

   // R4: summary can only be active with some enable bit set
   a_r4_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      sum_o |-> (en_o != '0));
endmodule

// File: rtl/irq_primary_tier.sv
module irq_primary_tier
   import irq_hub_pkg::*;
#(
   parameter bit OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [REG_W-1:0] wdata_i,
   input  logic             local_sum_i,
   input  logic             dma_flag_i,
   output prim_ctrl_t       ctrl_o,
   output logic             irq_n_o
);
   logic want_irq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_o <= '{led: 1'b1, dma_ie: 1'b0, local_ie: 1'b0, host_ie: 1'b0};
      end else if (wr_i) begin
         ctrl_o.led      <= wdata_i[B_LED];
         ctrl_o.dma_ie   <= wdata_i[B_DMA_IE];
         ctrl_o.local_ie <= wdata_i[B_LOCAL_IE];
         ctrl_o.host_ie  <= wdata_i[B_HOST_IE];
      end
   end

   assign want_irq = ctrl_o.host_ie &
                     ((ctrl_o.local_ie & local_sum_i) | (ctrl_o.dma_ie & dma_flag_i));

   if (OUT_REG) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_n_o <= 1'b1;
         else        irq_n_o <= ~want_irq;
      end
      // R5: host enable off keeps the line idle on the next cycle
      a_r5_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
         !ctrl_o.host_ie |=> irq_n_o);
      // R7: an enabled DMA completion asserts the line next cycle
      a_r7_dma_drives: assert property (@(posedge clk) disable iff (!rst_n)
         (ctrl_o.host_ie && ctrl_o.dma_ie && dma_flag_i) |=> !irq_n_o);
   end else begin : g_comb_out
      assign irq_n_o = ~want_irq;
      // R5
      a_r5_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
         !ctrl_o.host_ie |-> irq_n_o);
      // R7
      a_r7_dma_drives: assert property (@(posedge clk) disable iff (!rst_n)
         (ctrl_o.host_ie && ctrl_o.dma_ie && dma_flag_i) |-> !irq_n_o);
      // R4: local summary with local enable asserts the line
      a_r4_local_drives: assert property (@(posedge clk) disable iff (!rst_n)
         (ctrl_o.host_ie && ctrl_o.local_ie && local_sum_i) |-> !irq_n_o);
   end
endmodule

// File: rtl/irq_two_tier_hub.sv
module irq_two_tier_hub
   import irq_hub_pkg::*;
#(
   parameter int N_LOCAL = 4,
   parameter int N_LIVE  = 4,
   parameter int ADDR_W  = 3,
   parameter bit OUT_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LOCAL-1:0] local_evt_i,
   input  logic               dma_done_i,
   input  logic [N_LIVE-1:0]  live_i,
   input  logic               reg_wr_i,
   input  logic [ADDR_W-1:0]  reg_addr_i,
   input  logic [REG_W-1:0]   reg_wdata_i,
   output logic [REG_W-1:0]   reg_rdata_o,
   output logic               irq_n_o,
   output logic               led_o
);
   initial begin
      assert (N_LOCAL >= 1 && N_LOCAL <= B_PEND) else $error("N_LOCAL out of range");
      assert (N_LIVE >= 1 && N_LIVE <= REG_W)    else $error("N_LIVE out of range");
      assert (ADDR_W >= 3)                       else $error("ADDR_W too narrow");
   end

   logic             sel_ctrl, sel_lstat, sel_len, sel_live, sel_dma;
   logic [N_LOCAL-1:0] flags, enables;
   logic             local_sum, dma_flag, dma_clr;
   prim_ctrl_t       ctrl;
   logic             unused_wdata;

   assign sel_ctrl  = (reg_addr_i == ADDR_W'(SEL_CTRL));
   assign sel_lstat = (reg_addr_i == ADDR_W'(SEL_LSTAT));
   assign sel_len   = (reg_addr_i == ADDR_W'(SEL_LEN));
   assign sel_live  = (reg_addr_i == ADDR_W'(SEL_LIVE));
   assign sel_dma   = (reg_addr_i == ADDR_W'(SEL_DMA));
   assign unused_wdata = ^reg_wdata_i;

   irq_local_tier #(.N_LOCAL(N_LOCAL)) u_local (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_i     (local_evt_i),
      .wr_stat_i (reg_wr_i & sel_lstat),
      .wr_en_i   (reg_wr_i & sel_len),
      .wdata_i   (reg_wdata_i[N_LOCAL-1:0]),
      .flags_o   (flags),
      .en_o      (enables),
      .sum_o     (local_sum)
   );

   // DMA completion: write-one-to-clear on bit 0
   assign dma_clr = reg_wr_i & sel_dma & reg_wdata_i[0];

   irq_sticky_bank #(.WIDTH(1)) u_dma (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (dma_done_i),
      .clr_i (dma_clr),
      .q_o   (dma_flag)
   );

   irq_primary_tier #(.OUT_REG(OUT_REG)) u_prim (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_i        (reg_wr_i & sel_ctrl),
      .wdata_i     (reg_wdata_i),
      .local_sum_i (local_sum),
      .dma_flag_i  (dma_flag),
      .ctrl_o      (ctrl),
      .irq_n_o     (irq_n_o)
   );

   assign led_o = ctrl.led;

   always_comb begin
      reg_rdata_o = '0;
      if (sel_ctrl) begin
         reg_rdata_o[B_LED]      = ctrl.led;
         reg_rdata_o[B_PEND]     = local_sum;
         reg_rdata_o[B_DMA_IE]   = ctrl.dma_ie;
         reg_rdata_o[B_LOCAL_IE] = ctrl.local_ie;
         reg_rdata_o[B_HOST_IE]  = ctrl.host_ie;
      end else if (sel_lstat) begin
         reg_rdata_o[N_LOCAL-1:0] = flags;
      end else if (sel_len) begin
         reg_rdata_o[N_LOCAL-1:0] = enables;
      end else if (sel_live) begin
         reg_rdata_o[N_LIVE-1:0] = live_i;
      end else if (sel_dma) begin
         reg_rdata_o[0] = dma_flag;
      end
   end

   // R10: indicator output tracks a control write to bit 31 on the next cycle
   a_r10_led_write: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && sel_ctrl) |=> (led_o == $past(reg_wdata_i[B_LED])));
   // R6: writing zero to the DMA register never clears the flag
   a_r6_dma_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_flag && reg_wr_i && sel_dma && !reg_wdata_i[0]) |=> dma_flag);
endmodule

// File: tb/irq_two_tier_hub_test.sv
module irq_two_tier_hub_test;
   typedef struct packed {
      logic        wr;
      logic [2:0]  addr;
      logic [31:0] wdata;
      logic [3:0]  evt;
      logic        dma;
      logic [2:0]  raddr;
      logic [31:0] exp_rd;
      logic        exp_irq;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 3'd0, 32'h0,        4'b0001, 1'b0, 3'd1, 32'h1,        1'b1, 8'd1},
      '{1'b0, 3'd0, 32'h0,        4'b0100, 1'b0, 3'd1, 32'h5,        1'b1, 8'd1},
      '{1'b1, 3'd1, 32'hFFFFFFFE, 4'b0000, 1'b0, 3'd1, 32'h4,        1'b1, 8'd2},
      '{1'b1, 3'd1, 32'h0000000F, 4'b0000, 1'b0, 3'd1, 32'h4,        1'b1, 8'd2},
      '{1'b1, 3'd1, 32'h0,        4'b0100, 1'b0, 3'd1, 32'h4,        1'b1, 8'd3},
      '{1'b1, 3'd2, 32'h4,        4'b0000, 1'b0, 3'd0, 32'h80000100, 1'b1, 8'd11},
      '{1'b1, 3'd0, 32'h80000003, 4'b0000, 1'b0, 3'd0, 32'h80000103, 1'b0, 8'd4},
      '{1'b1, 3'd0, 32'h80000001, 4'b0000, 1'b0, 3'd0, 32'h80000101, 1'b1, 8'd4},
      '{1'b1, 3'd0, 32'h80000002, 4'b0000, 1'b0, 3'd0, 32'h80000102, 1'b1, 8'd5},
      '{1'b1, 3'd1, 32'h0,        4'b0000, 1'b0, 3'd1, 32'h0,        1'b1, 8'd2},
      '{1'b0, 3'd0, 32'h0,        4'b0000, 1'b1, 3'd4, 32'h1,        1'b1, 8'd6},
      '{1'b1, 3'd0, 32'h80000005, 4'b0000, 1'b0, 3'd0, 32'h80000005, 1'b0, 8'd7},
      '{1'b1, 3'd4, 32'h0,        4'b0000, 1'b0, 3'd4, 32'h1,        1'b0, 8'd6},
      '{1'b1, 3'd4, 32'h1,        4'b0000, 1'b0, 3'd4, 32'h0,        1'b1, 8'd6},
      '{1'b1, 3'd4, 32'h1,        4'b0000, 1'b1, 3'd4, 32'h1,        1'b0, 8'd3},
      '{1'b1, 3'd4, 32'h1,        4'b0000, 1'b0, 3'd4, 32'h0,        1'b1, 8'd6},
      '{1'b1, 3'd0, 32'h0,        4'b0000, 1'b0, 3'd0, 32'h0,        1'b1, 8'd10},
      '{1'b0, 3'd0, 32'h0,        4'b0010, 1'b0, 3'd0, 32'h0,        1'b1, 8'd4},
      '{1'b1, 3'd2, 32'h2,        4'b0000, 1'b0, 3'd0, 32'h100,      1'b1, 8'd11},
      '{1'b1, 3'd0, 32'h3,        4'b0000, 1'b0, 3'd0, 32'h103,      1'b0, 8'd4}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  local_evt = '0;
   logic        dma_done = 1'b0;
   logic [3:0]  live = '0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_n, led;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   irq_two_tier_hub uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .local_evt_i (local_evt),
      .dma_done_i  (dma_done),
      .live_i      (live),
      .reg_wr_i    (reg_wr),
      .reg_addr_i  (reg_addr),
      .reg_wdata_i (reg_wdata),
      .reg_rdata_o (reg_rdata),
      .irq_n_o     (irq_n),
      .led_o       (led)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   // drive at falling edge, let one rising edge pass, then point the read port
   task automatic step(input logic wr, input logic [2:0] a, input logic [31:0] d,
                       input logic [3:0] e, input logic dm, input logic [2:0] ra);
      @(negedge clk);
      reg_wr = wr; reg_addr = a; reg_wdata = d; local_evt = e; dma_done = dm;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0; local_evt = '0; dma_done = 1'b0; reg_addr = ra;
      #1;
   endtask

   task automatic peek(input logic [2:0] ra);
      reg_addr = ra;
      #1;
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(8 * 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: values held during reset and right after release
      peek(3'd0);
      check("R9 ctrl in reset", reg_rdata, 32'h80000000);
      check("R9 irq in reset", {31'b0, irq_n}, 32'h1);
      rst_n = 1'b1;
      @(negedge clk);
      peek(3'd0); check("R9 ctrl", reg_rdata, 32'h80000000);
      check("R9 led", {31'b0, led}, 32'h1);
      check("R9 irq", {31'b0, irq_n}, 32'h1);
      peek(3'd1); check("R9 flags", reg_rdata, 32'h0);
      peek(3'd2); check("R9 enables", reg_rdata, 32'h0);
      peek(3'd4); check("R9 dma", reg_rdata, 32'h0);

      for (int i = 0; i < NV; i++) begin
         step(VEC[i].wr, VEC[i].addr, VEC[i].wdata, VEC[i].evt, VEC[i].dma, VEC[i].raddr);
         check($sformatf("R%0d vec%0d rdata", VEC[i].req, i), reg_rdata, VEC[i].exp_rd);
         check($sformatf("R%0d vec%0d irq", VEC[i].req, i), {31'b0, irq_n}, {31'b0, VEC[i].exp_irq});
      end

      // R10: indicator follows bit 31
      check("R10 led off", {31'b0, led}, 32'h0);
      step(1'b1, 3'd0, 32'h80000000, 4'b0, 1'b0, 3'd0);
      check("R10 led on", {31'b0, led}, 32'h1);
      check("R10 ctrl read", reg_rdata, 32'h80000100);

      // R8: live view is unlatched and read-only
      live = 4'hA;
      peek(3'd3); check("R8 live now", reg_rdata, 32'hA);
      step(1'b1, 3'd3, 32'hFFFFFFFF, 4'b0, 1'b0, 3'd3);
      check("R8 live after write", reg_rdata, 32'hA);
      live = 4'h5; #1;
      check("R8 live follows input", reg_rdata, 32'h5);
      peek(3'd1); check("R8 flags untouched", reg_rdata, 32'h2);

      // R11: unused addresses read zero
      peek(3'd6); check("R11 unused addr", reg_rdata, 32'h0);

      // R12: interrupt falls only after the latching edge
      step(1'b1, 3'd1, 32'h0, 4'b0, 1'b0, 3'd0);
      step(1'b1, 3'd2, 32'h1, 4'b0, 1'b0, 3'd0);
      step(1'b1, 3'd0, 32'h80000003, 4'b0, 1'b0, 3'd0);
      check("R12 idle before event", {31'b0, irq_n}, 32'h1);
      @(negedge clk);
      local_evt = 4'b0001;
      #1 check("R12 no early assert", {31'b0, irq_n}, 32'h1);
      @(posedge clk); #1;
      check("R12 asserted after edge", {31'b0, irq_n}, 32'h0);
      @(negedge clk); local_evt = '0;

      // R3 on local flag held: clear and event for same bit together
      step(1'b1, 3'd1, 32'h0, 4'b0001, 1'b0, 3'd1);
      check("R3 local collide", reg_rdata, 32'h1);
      step(1'b1, 3'd1, 32'h0, 4'b0000, 1'b0, 3'd1);
      check("R2 final clear", reg_rdata, 32'h0);
      check("R2 irq released", {31'b0, irq_n}, 32'h1);

      finish_run();
   end
endmodule